// File: doc/BRIEF.md
# Parameterized Carry-Select Adder

This block adds two operands whose widths are set separately. It has no clock and no storage. The working width N is the larger of the two operand widths. The narrower operand is widened to N bits, and the result is N+1 bits wide, so it never overflows. A parameter selects how the narrower operand is widened and how the top result bit is formed: as the true two's-complement sum of signed operands, or as the carry of an unsigned addition.

The N working bits are split into consecutive slices, starting at bit 0 and moving upward. The lowest slice is a single ripple chain whose carry-in is fixed at zero. Every higher slice holds two ripple chains over the same bits. One chain assumes an incoming carry of 0 and the other assumes 1. The real carry from the slice below then picks one of the two precomputed sums. The slice's own carry is merged with AND/OR gates rather than a multiplexer. This keeps the critical path close to one slice of ripple plus one select stage per higher slice.

Because the block is combinational, the house preference for state machines does not apply. There are no states and no transitions: every output depends only on the present inputs.

Top module: `carry_select_adder`

## Requirements
- R1: With N = max(A_W, B_W), `sum_o` is N+1 bits wide and equals the sum of the two widened operands, reduced modulo 2^(N+1).
- R2: When SIGNED = 0, the narrower operand is widened with zero bits.
- R3: When SIGNED = 1, the narrower operand is widened by copying its most significant bit.
- R4: The slice size GRP_W defaults to 4. A value below 1 stops elaboration with a fatal message.
- R5: Slices are formed from bit 0 upward, each GRP_W bits wide. When fewer than GRP_W bits remain, the last slice covers only those bits, and the result is still the exact sum.
- R6: The lowest slice is one ripple chain with a carry-in of 0, and it produces result bits 0 to min(GRP_W, N)-1.
- R7: In every higher slice, the chain with carry-in 1 produces the value of the carry-in-0 chain plus one. The sum bits come from the carry-in-1 chain exactly when the carry from the slice below is 1.
- R8: A higher slice's carry-out equals c0 OR (c1 AND cin), where c0 and c1 are the carry-outs of its two chains and cin is the carry from the slice below. c0 = 1 implies c1 = 1.
- R9: When SIGNED = 0, `sum_o[N]` is the carry-out of the top slice.
- R10: When SIGNED = 1, `sum_o[N]` is a[N-1] XOR b[N-1] XOR the top slice's carry-out, taken on the widened operands. This makes `sum_o` the correct two's-complement sum.
- R11: A slice size of 1, and a slice size of N or more (a single slice), both give the exact sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | A_W | First operand |
| b_i | input | B_W | Second operand |
| sum_o | output | max(A_W,B_W)+1 | Full-width sum |

## Verification
The hardest case to reach is a carry that must pass through several higher slices, which needs every bit of those slices to propagate. Negative narrow operands are equally hard, because they must be widened correctly and then meet a positive wide operand. Exhaustive sweeps at widths 5 and 6 cover every carry pattern for slice sizes that divide N, that leave a short last slice, that equal 1, and that exceed N. At 32 bits, directed all-zero and all-one operands force the full propagate path, and random values cover the rest in both signed and unsigned mode.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Larger of two widths; used for the working width and the port width.
    function automatic int wmax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // Number of slices needed to cover n bits in steps of g.
    function automatic int slice_count(input int n, input int g);
        return (n + g - 1) / g;
    endfunction

endpackage

// File: rtl/csa_extend.sv
module csa_extend #(
    parameter int IN_W   = 4,
    parameter int OUT_W  = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o
);
    localparam int PAD_W = (OUT_W > IN_W) ? (OUT_W - IN_W) : 1;

    generate
        if (IN_W == OUT_W) begin : g_same
            assign val_o = val_i;
        end else if (SIGNED) begin : g_sext
            // R3: replicate the operand's top bit
            assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
        end else begin : g_zext
            // R2: pad with zeros
            assign val_o = {{PAD_W{1'b0}}, val_i};
        end
    endgenerate
endmodule

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] cy;

    assign cy[0] = cin_i;

    generate
        for (genvar k = 0; k < W; k++) begin : g_fa
            logic prop;
            assign prop      = a_i[k] ^ b_i[k];
            assign sum_o[k]  = prop ^ cy[k];
            assign cy[k+1]   = (a_i[k] & b_i[k]) | (prop & cy[k]);
        end
    endgenerate

    assign cout_o = cy[W];
endmodule

// File: rtl/csa_group.sv
module csa_group #(
    parameter int W      = 4,
    parameter bit LOWEST = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    generate
        if (LOWEST) begin : g_low
            // R6: lowest slice is one chain fed by the real carry-in (tied 0 above)
            csa_ripple #(.W(W)) u_chain (
                .a_i    (a_i),
                .b_i    (b_i),
                .cin_i  (cin_i),
                .sum_o  (sum_o),
                .cout_o (cout_o)
            );
        end else begin : g_dual
            logic [W-1:0] s0;
            logic [W-1:0] s1;
            logic         c0;
            logic         c1;

            csa_ripple #(.W(W)) u_chain0 (
                .a_i    (a_i),
                .b_i    (b_i),
                .cin_i  (1'b0),
                .sum_o  (s0),
                .cout_o (c0)
            );

            csa_ripple #(.W(W)) u_chain1 (
                .a_i    (a_i),
                .b_i    (b_i),
                .cin_i  (1'b1),
                .sum_o  (s1),
                .cout_o (c1)
            );

            // R7: select the precomputed sum with the incoming carry
            always_comb begin
                sum_o = cin_i ? s1 : s0;
            end

            // R8: AND/OR merge of the two chain carries
            always_comb begin
                cout_o = c0 | (c1 & cin_i);
            end

            always_comb begin
                if (!$isunknown({a_i, b_i})) begin
                    // R7
                    chain_pair_chk: assert ({c1, s1} == ({c0, s0} + (W+1)'(1)))
                        else $error("carry-in-1 chain is not carry-in-0 chain plus one");
                    // R8
                    carry_order_chk: assert (!c0 || c1)
                        else $error("chain carry order violated");
                end
            end
        end
    endgenerate
endmodule

// File: rtl/carry_select_adder.sv
module carry_select_adder
    import csa_pkg::*;
#(
    parameter int A_W    = 16,
    parameter int B_W    = 12,
    parameter int GRP_W  = 4,
    parameter bit SIGNED = 1'b0
) (
    input  logic [A_W-1:0]           a_i,
    input  logic [B_W-1:0]           b_i,
    output logic [wmax(A_W, B_W):0]  sum_o
);
    localparam int N      = wmax(A_W, B_W);
    localparam int G_SAFE = (GRP_W < 1) ? 1 : GRP_W;
    localparam int NGRP   = slice_count(N, G_SAFE);

    // R4: a non-positive slice size is rejected at elaboration
    generate
        if (GRP_W < 1) begin : g_bad_size
            $fatal(1, "slice size must be at least 1");
        end
    endgenerate

    logic [N-1:0]  ea;
    logic [N-1:0]  eb;
    logic [N-1:0]  low_sum;
    logic [NGRP:0] gc;

    csa_extend #(.IN_W(A_W), .OUT_W(N), .SIGNED(SIGNED)) u_ext_a (
        .val_i (a_i),
        .val_o (ea)
    );

    csa_extend #(.IN_W(B_W), .OUT_W(N), .SIGNED(SIGNED)) u_ext_b (
        .val_i (b_i),
        .val_o (eb)
    );

    assign gc[0] = 1'b0;

    // R5: slices from bit 0 upward, last one may be short
    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_slice
            localparam int LO = g * G_SAFE;
            localparam int GW = ((N - LO) < G_SAFE) ? (N - LO) : G_SAFE;
            csa_group #(.W(GW), .LOWEST(g == 0)) u_grp (
                .a_i    (ea[LO +: GW]),
                .b_i    (eb[LO +: GW]),
                .cin_i  (gc[g]),
                .sum_o  (low_sum[LO +: GW]),
                .cout_o (gc[g+1])
            );
        end
    endgenerate

    generate
        if (SIGNED) begin : g_top_signed
            // R10: top bit restores the sign of the N+1 bit sum
            assign sum_o = {ea[N-1] ^ eb[N-1] ^ gc[NGRP], low_sum};

            always_comb begin
                if (!$isunknown({a_i, b_i})) begin
                    // R10
                    signed_sum_chk: assert ($signed(sum_o) ==
                                            ($signed({ea[N-1], ea}) + $signed({eb[N-1], eb})))
                        else $error("signed sum mismatch");
                end
            end
        end else begin : g_top_unsigned
            // R9: top bit is the final slice carry
            assign sum_o = {gc[NGRP], low_sum};

            always_comb begin
                if (!$isunknown({a_i, b_i})) begin
                    // R9
                    unsigned_sum_chk: assert (sum_o == ({1'b0, ea} + {1'b0, eb}))
                        else $error("unsigned sum mismatch");
                end
            end
        end
    endgenerate

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            // R6
            low_slice_chk: assert (sum_o[0] == (ea[0] ^ eb[0]))
                else $error("bit 0 does not see a zero carry-in");
        end
    end
endmodule

// File: tb/carry_select_adder_tb.sv
module carry_select_adder_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    // Config A: 6x6 unsigned, default slice size 4 (does not divide 6)
    logic [5:0]  a0, b0;
    logic [6:0]  s0;
    carry_select_adder #(.A_W(6), .B_W(6), .SIGNED(1'b0)) u_dut (
        .a_i(a0), .b_i(b0), .sum_o(s0));

    // Config B: 6x5 signed, slice 4
    logic [5:0]  a1;
    logic [4:0]  b1;
    logic [6:0]  s1;
    carry_select_adder #(.A_W(6), .B_W(5), .GRP_W(4), .SIGNED(1'b1)) u_dut_s6 (
        .a_i(a1), .b_i(b1), .sum_o(s1));

    // Config C: 5x5 signed, slice 1
    logic [4:0]  a2, b2;
    logic [5:0]  s2;
    carry_select_adder #(.A_W(5), .B_W(5), .GRP_W(1), .SIGNED(1'b1)) u_dut_g1 (
        .a_i(a2), .b_i(b2), .sum_o(s2));

    // Config D: 5x3 unsigned, slice 8 (>= N)
    logic [4:0]  a3;
    logic [2:0]  b3;
    logic [5:0]  s3;
    carry_select_adder #(.A_W(5), .B_W(3), .GRP_W(8), .SIGNED(1'b0)) u_dut_big (
        .a_i(a3), .b_i(b3), .sum_o(s3));

    // Config E: 32x20 signed, slice 5
    logic [31:0] a4;
    logic [19:0] b4;
    logic [32:0] s4;
    carry_select_adder #(.A_W(32), .B_W(20), .GRP_W(5), .SIGNED(1'b1)) u_dut_w (
        .a_i(a4), .b_i(b4), .sum_o(s4));

    // Config F: 24x32 unsigned, slice 7
    logic [23:0] a5;
    logic [31:0] b5;
    logic [32:0] s5;
    carry_select_adder #(.A_W(24), .B_W(32), .GRP_W(7), .SIGNED(1'b0)) u_dut_wu (
        .a_i(a5), .b_i(b5), .sum_o(s5));

    function automatic longint widen(longint v, int w, bit sgn);
        longint m;
        m = (longint'(1) << w) - 1;
        v = v & m;
        if (sgn && v[w-1]) v = v | ~m;
        return v;
    endfunction

    function automatic longint model(longint a, int aw, longint b, int bw, bit sgn);
        int n;
        longint r;
        n = (aw > bw) ? aw : bw;
        r = widen(a, aw, sgn) + widen(b, bw, sgn);
        return r & ((longint'(1) << (n + 1)) - 1);
    endfunction

    task automatic check(string tag, longint got, longint exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic compare_all();
        check("R1/R2/R4/R5/R9 u_dut", longint'(s0), model(longint'(a0), 6, longint'(b0), 6, 1'b0));
        check("R3/R5/R10 u_dut_s6",   longint'(s1), model(longint'(a1), 6, longint'(b1), 5, 1'b1));
        check("R7/R8/R11 u_dut_g1",   longint'(s2), model(longint'(a2), 5, longint'(b2), 5, 1'b1));
        check("R2/R6/R11 u_dut_big",  longint'(s3), model(longint'(a3), 5, longint'(b3), 3, 1'b0));
        check("R3/R8/R10 u_dut_w",    longint'(s4), model(longint'(a4), 32, longint'(b4), 20, 1'b1));
        check("R2/R7/R9 u_dut_wu",    longint'(s5), model(longint'(a5), 24, longint'(b5), 32, 1'b0));
    endtask

    initial begin
        {a0, b0, a1, b1, a2, b2, a3, b3, a4, b4, a5, b5} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: zero operands held through reset give a zero sum
        check("R1 reset zero", longint'(s0), 0);
        check("R1 reset zero wide", longint'(s4), 0);
        rst_n = 1'b1;

        for (int i = 0; i < 4096; i++) begin
            @(posedge clk);
            a0 = i[5:0];  b0 = i[11:6];
            a1 = i[5:0];  b1 = i[10:6];
            a2 = i[4:0];  b2 = i[9:5];
            a3 = i[4:0];  b3 = i[7:5];
            if (i < 4) begin
                // long propagate paths: all-ones against all-zeros and against itself
                a4 = i[0] ? '1 : '0;  b4 = i[1] ? '1 : 20'd1;
                a5 = i[0] ? '1 : '0;  b5 = i[1] ? '1 : 32'd1;
            end else begin
                a4 = $urandom();  b4 = 20'($urandom());
                a5 = 24'($urandom());  b5 = $urandom();
            end
            @(negedge clk);
            compare_all();
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule